// File: doc/BRIEF.md
# Dual-Rate Receive Squelch Controller

This block sits behind the threshold comparators of a twisted-pair line receiver. It decides whether the line carries real signal or only noise. The comparators deliver single-cycle pulses when the input swings past the positive or the negative threshold. The controller looks for crossings that alternate in polarity and arrive fast enough. When it sees them, it opens (leaves the squelched state) and tells the analog side to use a lower, hysteretic threshold.

Two line rates are handled. In the fast rate the controller needs four alternating crossings inside a window of about ten microseconds. It closes again after a full window passes with no alternating crossing, and its open status feeds link-integrity logic elsewhere. In the slow rate it needs three alternating crossings, each spaced between fifty and two hundred fifty nanoseconds from the one before. It stays open until the receiver reports the start of idle, and its open status is the carrier-sense flag that marks the start of a packet. All windows are cycle counts derived from a clock-period parameter. A separate control bit lowers both threshold levels by a fixed 4.5 dB step so that longer cables can be used.

Top module: `sqc_squelch_ctl`

## Requirements
- R1: After reset the block is squelched: `open_o`=0, `carrier`=0, `link_ok`=0, and `thr_sel[0]`=0.
- R2: In the fast rate (`rate_slow`=0), a squelched block opens on the clock edge that samples the fourth of four consecutive alternating crossings, provided the span from the first to the fourth is at most WIN cycles (WIN = 10 us / clock period, 2500 at defaults). The window slides, so any four consecutive alternating crossings qualify. The change shows on `open_o` right after that edge.
- R3: `thr_sel` is a 2-bit code. Bit 0 is 1 while open (reduced hysteretic level) and 0 while squelched (full level). Bit 1 follows `lvl_adj` (1 = both levels lowered by 4.5 dB).
- R4: In the fast rate, an open block closes on the edge that completes WIN cycles after the last alternating crossing with no alternating crossing in between. An alternating crossing sampled exactly on that WIN-th edge keeps the block open and restarts the interval.
- R5: In the slow rate (`rate_slow`=1), a squelched block opens on the edge that samples the third of three consecutive alternating crossings, each gap being between GMIN and GMAX cycles inclusive (GMIN = ceil(50 ns / period) = 13, GMAX = floor(250 ns / period) = 62 at defaults).
- R6: In the slow rate, an open block closes only on an edge that samples `idle_start`=1. It has no timeout. In the fast rate, `idle_start` has no effect.
- R7: `carrier` is 1 exactly when the block is open in the slow rate. `link_ok` is 1 exactly when it is open in the fast rate.
- R8: A crossing with the same polarity as the previous one restarts qualification at one, with the new polarity remembered. A cycle with both `pos_hit` and `neg_hit` high is not a crossing. A same-polarity crossing does not restart the fast-rate close interval.
- R9: In the slow rate, a crossing whose gap is below GMIN or above GMAX restarts qualification at one, counting from that crossing.
- R10: A change of `rate_slow` forces the squelched state on the next edge and clears all polarity history, crossing counts and interval counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_slow | input | 1 | 1 selects the slow line rate, 0 the fast one |
| pos_hit | input | 1 | Single-cycle pulse: input passed the positive threshold |
| neg_hit | input | 1 | Single-cycle pulse: input passed the negative threshold |
| idle_start | input | 1 | Receiver reports end of packet (start of idle), slow rate only |
| lvl_adj | input | 1 | Lower both threshold levels by 4.5 dB |
| open_o | output | 1 | 1 = unsquelched (signal valid) |
| thr_sel | output | 2 | Threshold code {lvl_adj, open} for the comparators |
| carrier | output | 1 | Carrier sense, slow rate |
| link_ok | output | 1 | Link-integrity input, fast rate |

## Verification
A stale crossing count or a wrong polarity memory shows up on `open_o` at the very edge that samples the deciding crossing: the block opens one crossing too early or too late. An interval counter that is off by one moves the fast-rate close by a single cycle, so the bench samples `open_o` one cycle before and exactly at the WIN-th edge. Gap-window errors show in a sweep of slow-rate spacings across both bounds. History that survives a rate change shows as an early open within the first few crossings after the switch.

// File: rtl/sqc_pkg.sv
package sqc_pkg;

    typedef enum logic {
        ST_SQUELCH = 1'b0,
        ST_OPEN    = 1'b1
    } sq_state_e;

    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } pol_e;

    // One sampled comparator event: a valid crossing and whether it
    // alternates with the crossing before it.
    typedef struct packed {
        logic hit;
        logic alt;
    } xing_t;

    function automatic int unsigned cyc_floor(input int unsigned span_ps,
                                              input int unsigned clk_ps);
        return span_ps / clk_ps;
    endfunction

    function automatic int unsigned cyc_ceil(input int unsigned span_ps,
                                             input int unsigned clk_ps);
        return (span_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned umax(input int unsigned a,
                                         input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sqc_xing_track.sv
module sqc_xing_track
    import sqc_pkg::*;
#(
    parameter int unsigned AW   = 12,
    parameter int unsigned SAT  = 2500,
    parameter int unsigned HIST = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          pos_hit,
    input  logic          neg_hit,
    output xing_t         xing,
    output logic [AW-1:0] age_near,
    output logic [AW-1:0] age_far
);

    localparam logic [AW-1:0] SAT_V = AW'(SAT);

    pol_e          last_pol_q;
    logic          pol_valid_q;
    logic [AW-1:0] age_q [HIST];
    pol_e          cur_pol;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] v);
        return (v >= SAT_V) ? SAT_V : v + 1'b1;
    endfunction

    always_comb begin
        cur_pol  = pos_hit ? POL_POS : POL_NEG;
        xing.hit = pos_hit ^ neg_hit;
        xing.alt = (pos_hit ^ neg_hit) && pol_valid_q && (cur_pol != last_pol_q);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            last_pol_q  <= POL_POS;
            pol_valid_q <= 1'b0;
            for (int i = 0; i < HIST; i++) age_q[i] <= SAT_V;
        end else if (xing.hit) begin
            last_pol_q  <= cur_pol;
            pol_valid_q <= 1'b1;
            age_q[0]    <= '0;
            for (int i = 1; i < HIST; i++) age_q[i] <= bump(age_q[i-1]);
        end else begin
            for (int i = 0; i < HIST; i++) age_q[i] <= bump(age_q[i]);
        end
    end

    assign age_near = age_q[0];
    assign age_far  = age_q[HIST-1];

    // Older crossings are never younger than newer ones (R2).
    for (genvar g = 1; g < HIST; g++) begin : g_order
        p_age_order_r2: assert property (@(posedge clk) disable iff (rst)
            age_q[g] >= age_q[g-1]);
    end

endmodule

// File: rtl/sqc_qualify.sv
module sqc_qualify
    import sqc_pkg::*;
#(
    parameter int unsigned AW        = 12,
    parameter int unsigned WIN       = 2500,
    parameter int unsigned GMIN      = 13,
    parameter int unsigned GMAX      = 62,
    parameter int unsigned FAST_HITS = 4,
    parameter int unsigned SLOW_HITS = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          slow,
    input  xing_t         xing,
    input  logic [AW-1:0] age_near,
    input  logic [AW-1:0] age_far,
    output logic          qual
);

    localparam int unsigned CAP = umax(FAST_HITS, SLOW_HITS);
    localparam int unsigned RW  = $clog2(CAP + 1);

    localparam logic [RW-1:0] CAP_V     = RW'(CAP);
    localparam logic [RW-1:0] FAST_NEED = RW'(FAST_HITS - 1);
    localparam logic [RW-1:0] SLOW_NEED = RW'(SLOW_HITS - 1);
    localparam logic [AW-1:0] WIN_M1    = AW'(WIN - 1);
    localparam logic [AW-1:0] GMIN_M1   = AW'(GMIN - 1);
    localparam logic [AW-1:0] GMAX_M1   = AW'(GMAX - 1);

    logic [RW-1:0] run_q;
    logic          gap_ok, fast_ok, slow_ok, extend;

    always_comb begin
        gap_ok  = (age_near >= GMIN_M1) && (age_near <= GMAX_M1);
        fast_ok = xing.alt && (run_q >= FAST_NEED) && (age_far <= WIN_M1);
        slow_ok = xing.alt && gap_ok && (run_q >= SLOW_NEED);
        qual    = slow ? slow_ok : fast_ok;
        extend  = xing.alt && (!slow || gap_ok);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q <= '0;
        end else if (xing.hit) begin
            if (!extend)             run_q <= RW'(1);
            else if (run_q != CAP_V) run_q <= run_q + 1'b1;
        end
    end

    // A crossing that breaks the pattern leaves exactly one counted (R8, R9).
    p_restart_one_r9: assert property (@(posedge clk) disable iff (rst)
        $past(xing.hit) && !$past(xing.alt) && !$past(clr) |-> run_q == RW'(1));

endmodule

// File: rtl/sqc_idle_timer.sv
module sqc_idle_timer #(
    parameter int unsigned AW  = 12,
    parameter int unsigned WIN = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic alt_hit,
    output logic timeout
);

    localparam logic [AW-1:0] WIN_V  = AW'(WIN);
    localparam logic [AW-1:0] WIN_M1 = AW'(WIN - 1);

    logic [AW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr || alt_hit) cnt_q <= '0;
        else if (cnt_q != WIN_V)   cnt_q <= cnt_q + 1'b1;
    end

    assign timeout = (cnt_q == WIN_M1) && !alt_hit;

    // The counter never passes its saturation value (R4).
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= WIN_V);

endmodule

// File: rtl/sqc_squelch_ctl.sv
module sqc_squelch_ctl
    import sqc_pkg::*;
#(
    parameter int unsigned CLK_PS      = 4000,
    parameter int unsigned FAST_WIN_PS = 10_000_000,
    parameter int unsigned SLOW_MIN_PS = 50_000,
    parameter int unsigned SLOW_MAX_PS = 250_000,
    parameter int unsigned FAST_HITS   = 4,
    parameter int unsigned SLOW_HITS   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rate_slow,
    input  logic       pos_hit,
    input  logic       neg_hit,
    input  logic       idle_start,
    input  logic       lvl_adj,
    output logic       open_o,
    output logic [1:0] thr_sel,
    output logic       carrier,
    output logic       link_ok
);

    localparam int unsigned WIN  = cyc_floor(FAST_WIN_PS, CLK_PS);
    localparam int unsigned GMIN = cyc_ceil(SLOW_MIN_PS, CLK_PS);
    localparam int unsigned GMAX = cyc_floor(SLOW_MAX_PS, CLK_PS);
    localparam int unsigned SAT  = umax(WIN, GMAX + 1);
    localparam int unsigned AW   = $clog2(SAT + 1);
    localparam int unsigned HIST = FAST_HITS - 1;

    sq_state_e     state_q;
    logic          rate_q;
    logic          rate_chg, leave, clr;
    logic          qual, timeout;
    xing_t         xing;
    logic [AW-1:0] age_near, age_far;

    sqc_xing_track #(.AW(AW), .SAT(SAT), .HIST(HIST)) u_track (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .pos_hit  (pos_hit),
        .neg_hit  (neg_hit),
        .xing     (xing),
        .age_near (age_near),
        .age_far  (age_far)
    );

    sqc_qualify #(
        .AW(AW), .WIN(WIN), .GMIN(GMIN), .GMAX(GMAX),
        .FAST_HITS(FAST_HITS), .SLOW_HITS(SLOW_HITS)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .slow     (rate_q),
        .xing     (xing),
        .age_near (age_near),
        .age_far  (age_far),
        .qual     (qual)
    );

    sqc_idle_timer #(.AW(AW), .WIN(WIN)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .alt_hit (xing.alt),
        .timeout (timeout)
    );

    always_comb begin
        rate_chg = (rate_q != rate_slow);
        leave    = (state_q == ST_OPEN) && (rate_q ? idle_start : timeout);
        clr      = rate_chg || leave;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SQUELCH;
        end else if (clr) begin
            state_q <= ST_SQUELCH;
        end else if ((state_q == ST_SQUELCH) && qual) begin
            state_q <= ST_OPEN;
        end
        rate_q <= rate_slow;
    end

    assign open_o  = (state_q == ST_OPEN);
    assign thr_sel = {lvl_adj, open_o};
    assign carrier = open_o && rate_q;
    assign link_ok = open_o && !rate_q;

    p_reset_squelch_r1: assert property (@(posedge clk)
        rst |=> !open_o);

    p_open_on_crossing_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> $past(pos_hit ^ neg_hit));

    p_fast_close_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(open_o) && !rate_q && $stable(rate_q) |-> !$past(xing.alt));

    p_slow_close_idle_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(open_o) && rate_q && $stable(rate_q) |-> $past(idle_start));

    p_rate_forces_squelch_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(rate_slow) |=> !open_o);

endmodule

// File: tb/tb_sqc_squelch_ctl.sv
module tb_sqc_squelch_ctl;

    localparam int CLK_PS = 4000;
    localparam int WIN    = 10_000_000 / CLK_PS;
    localparam int GMIN   = (50_000 + CLK_PS - 1) / CLK_PS;
    localparam int GMAX   = 250_000 / CLK_PS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rate_slow = 1'b0;
    logic       pos_hit = 1'b0;
    logic       neg_hit = 1'b0;
    logic       idle_start = 1'b0;
    logic       lvl_adj = 1'b0;
    logic       open_o;
    logic [1:0] thr_sel;
    logic       carrier;
    logic       link_ok;

    int total = 0;
    int bad   = 0;

    always #2ns clk = ~clk;

    sqc_squelch_ctl #(.CLK_PS(CLK_PS)) dut (
        .clk(clk), .rst(rst), .rate_slow(rate_slow),
        .pos_hit(pos_hit), .neg_hit(neg_hit), .idle_start(idle_start),
        .lvl_adj(lvl_adj), .open_o(open_o), .thr_sel(thr_sel),
        .carrier(carrier), .link_ok(link_ok)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pol: 1 = positive crossing, 0 = negative crossing
    task automatic hit(input bit pol);
        pos_hit = pol;
        neg_hit = !pol;
        @(negedge clk);
        pos_hit = 1'b0;
        neg_hit = 1'b0;
    endtask

    task automatic hit_gap(input bit pol, input int gap);
        idle(gap - 1);
        hit(pol);
    endtask

    task automatic both_hit();
        pos_hit = 1'b1;
        neg_hit = 1'b1;
        @(negedge clk);
        pos_hit = 1'b0;
        neg_hit = 1'b0;
    endtask

    task automatic pulse_idle();
        idle_start = 1'b1;
        @(negedge clk);
        idle_start = 1'b0;
    endtask

    task automatic fast_open_quick();
        hit(1); hit_gap(0, 5); hit_gap(1, 5); hit_gap(0, 5);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);

        // ---- R1 reset state
        chk("R1 open", open_o, 0);
        chk("R1 thr", thr_sel, 0);
        chk("R1 carrier", carrier, 0);
        chk("R1 link", link_ok, 0);

        // ---- R2 fast entry, span exactly WIN
        hit(1); hit_gap(0, 1000); hit_gap(1, 1000);
        chk("R2 three crossings", open_o, 0);
        hit_gap(0, WIN - 2000);
        chk("R2 span=WIN opens", open_o, 1);
        chk("R3 thr open", thr_sel, 1);
        chk("R7 link", link_ok, 1);
        chk("R7 carrier fast", carrier, 0);
        lvl_adj = 1'b1;
        idle(1);
        chk("R3 thr open adj", thr_sel, 3);

        // ---- R4 close exactly WIN after last alternating crossing
        idle(WIN - 2);
        chk("R4 WIN-1 still open", open_o, 1);
        idle(1);
        chk("R4 WIN closes", open_o, 0);
        chk("R3 thr squelch adj", thr_sel, 2);
        lvl_adj = 1'b0;
        idle(1);
        chk("R3 thr squelch", thr_sel, 0);

        // ---- R2 span WIN+1 fails, sliding window then qualifies
        idle(WIN + 5);
        hit(1); hit_gap(0, 1000); hit_gap(1, 1000); hit_gap(0, WIN - 1999);
        chk("R2 span=WIN+1 stays", open_o, 0);
        hit_gap(1, 10);
        chk("R2 sliding window opens", open_o, 1);
        idle(WIN + 5);
        chk("R4 timed out", open_o, 0);

        // ---- R4 crossing on the WIN-th edge keeps open
        fast_open_quick();
        chk("R2 quick open", open_o, 1);
        idle(WIN - 1);
        hit(1);
        chk("R4 crossing at WIN keeps", open_o, 1);
        idle(WIN - 1);
        chk("R4 restarted interval", open_o, 1);
        idle(1);
        chk("R4 closes after restart", open_o, 0);

        // ---- R8 same-polarity crossing does not restart close interval
        idle(WIN + 5);
        fast_open_quick();           // last polarity negative
        hit_gap(0, 100);
        chk("R8 same pol open", open_o, 1);
        idle(WIN - 101);
        chk("R8 before WIN", open_o, 1);
        idle(1);
        chk("R8 close at WIN from last alt", open_o, 0);

        // ---- R8 same polarity restarts count
        idle(WIN + 5);
        hit(1); hit_gap(0, 5); hit_gap(0, 5); hit_gap(1, 5); hit_gap(0, 5);
        chk("R8 restart not yet", open_o, 0);
        hit_gap(1, 5);
        chk("R8 opens after restart", open_o, 1);
        idle(WIN + 5);

        // ---- R8 simultaneous pulses ignored
        hit(1); hit_gap(0, 5); hit_gap(1, 5);
        idle(4); both_hit();
        chk("R8 both ignored", open_o, 0);
        hit_gap(0, 5);
        chk("R8 fourth after both opens", open_o, 1);

        // ---- R6 idle_start ignored in fast rate
        pulse_idle();
        chk("R6 fast idle ignored", open_o, 1);
        idle(WIN + 5);

        // ---- R2 sweep of span around WIN
        for (int s = WIN - 2; s <= WIN + 2; s++) begin
            int g1;
            g1 = s / 3;
            idle(WIN + 5);
            hit(1); hit_gap(0, g1); hit_gap(1, g1);
            hit_gap(0, s - 2 * g1);
            chk("R2 sweep", open_o, (s <= WIN) ? 1 : 0);
        end
        idle(WIN + 5);

        // ---- R10 rate change forces squelch
        fast_open_quick();
        chk("R10 pre open", open_o, 1);
        rate_slow = 1'b1;
        idle(1);
        chk("R10 forced squelch", open_o, 0);
        chk("R7 carrier after switch", carrier, 0);

        // ---- R5 slow entry at both gap bounds
        idle(100);
        hit(1); hit_gap(0, GMIN);
        chk("R5 two crossings", open_o, 0);
        hit_gap(1, GMAX);
        chk("R5 opens at bounds", open_o, 1);
        chk("R7 carrier", carrier, 1);
        chk("R7 link slow", link_ok, 0);
        chk("R3 thr slow open", thr_sel, 1);

        // ---- R6 no timeout in slow rate, idle_start closes
        idle(WIN + 100);
        chk("R6 no timeout", open_o, 1);
        pulse_idle();
        chk("R6 idle closes", open_o, 0);
        chk("R7 carrier drop", carrier, 0);

        // ---- R9 early gap restarts
        idle(100);
        hit(1); hit_gap(0, GMIN - 1); hit_gap(1, GMIN);
        chk("R9 early restart", open_o, 0);
        hit_gap(0, GMIN);
        chk("R9 opens after early", open_o, 1);
        pulse_idle();

        // ---- R9 late gap restarts
        idle(100);
        hit(1); hit_gap(0, GMAX + 1); hit_gap(1, GMAX);
        chk("R9 late restart", open_o, 0);
        hit_gap(0, GMAX);
        chk("R9 opens after late", open_o, 1);
        pulse_idle();

        // ---- R8 same polarity in slow rate
        idle(100);
        hit(1); hit_gap(1, 20); hit_gap(0, 20);
        chk("R8 slow restart", open_o, 0);
        hit_gap(1, 20);
        chk("R8 slow opens", open_o, 1);
        pulse_idle();

        // ---- R5 / R9 sweep of equal gaps
        for (int g = GMIN - 3; g <= GMAX + 4; g++) begin
            idle(100);
            hit(1); hit_gap(0, g); hit_gap(1, g);
            chk("R5 sweep", open_o, (g >= GMIN && g <= GMAX) ? 1 : 0);
            if (open_o) pulse_idle();
        end

        // ---- R10 switch clears crossing history
        idle(100);
        hit(1); hit_gap(0, 20);
        rate_slow = 1'b0;
        idle(1);
        hit_gap(1, 20); hit_gap(0, 20);
        chk("R10 history cleared 2", open_o, 0);
        hit_gap(1, 20);
        chk("R10 history cleared 3", open_o, 0);
        hit_gap(0, 20);
        chk("R10 fourth opens", open_o, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule